// File: doc/BRIEF.md
# Reset and Interrupt Event Gate

This block sits at the front of a pipeline and decides, each time the pipeline advances by one cycle, whether the coming instruction fetch is pre-empted. There are three outcomes: a reset-class action, an interrupt, or normal flow. The decision uses a level-sensitive pending-event vector and a few status-register fields.

The lowest eight event bits are reset-class sources: cold reset at bit 0, soft reset at bit 1, non-maskable interrupt at bit 2, and bits 3 to 7 below those. The bits above them are interrupt lines. Mask bit k of the status register enables event bit 8+k.

Each decision comes out one clock after the step that sampled it. It appears as a one-cycle pulse on either the reset output or the interrupt output, together with the index of the winning event bit. The consumer clears event bits itself. It also raises the exception or error level after a take, and the gate waits to see that raised level before it allows another interrupt.

Top module: `evt_gate`

## Requirements
- R1: While `rst` is high and in the first cycle after it, both take outputs and `causeIdx` are 0, and the interrupt hold-off is cleared, so an enabled, unmasked line is taken on the first step after reset.
- R2: A step with `eventVec` all zero produces no take in the next cycle.
- R3: A step with any of `eventVec[7:0]` set produces `takeReset`=1 in the next cycle, whatever the values of `intEnable`, `excLevel`, `errLevel` and `intMask`, unless `takeReset` is already 1 in the stepping cycle.
- R4: On a reset-class take, `causeIdx` is the lowest set index in `eventVec[7:0]`: bit 0 (cold) beats bit 1 (soft), and bit 1 beats bit 2 (NMI).
- R5: An interrupt is taken only from a step in which `intEnable`=1, `excLevel`=0 and `errLevel`=0.
- R6: An interrupt also needs `eventVec[8+k]` and `intMask[k]` both set for some k.
- R7: On an interrupt take, `causeIdx` is 8 plus the lowest k for which `eventVec[8+k]` and `intMask[k]` are both set.
- R8: A step with any reset-class bit set never produces `takeIrq`.
- R9: When `pipeStep`=0, the next cycle has no take.
- R10: `takeReset` is never high in two consecutive cycles, and `causeIdx` is 0 in any cycle without a take.
- R11: After any take, no interrupt is taken until a cycle has had `excLevel`=1 or `errLevel`=1 at its clock edge.
- R12: `takeReset` and `takeIrq` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pipeStep | input | 1 | The pipeline advances this cycle; evaluate the events |
| eventVec | input | 8+NUM_IRQ | Pending events: reset class in [7:0], interrupt lines above |
| intEnable | input | 1 | Interrupt enable bit from status |
| excLevel | input | 1 | Exception level bit from status |
| errLevel | input | 1 | Error level bit from status |
| intMask | input | NUM_IRQ | Per-line interrupt mask from status |
| takeReset | output | 1 | One-cycle reset-class take pulse |
| takeIrq | output | 1 | One-cycle interrupt take pulse |
| causeIdx | output | $clog2(8+NUM_IRQ) | Index of the winning event bit, 0 when idle |

## Verification
The hardest state to reach is the interrupt hold-off after a take. It is invisible at the ports until a line that would otherwise be taken is refused, and it changes only when the status levels move. The stimulus keeps an enabled, unmasked line pending across a take and shows that it is refused. It then raises the exception level for one step and shows that the same line is taken again. A second path puts a reset-class bit in the step just after a reset take, with the hold-off already cleared. That step shows the pulse rule and the override of interrupts acting on their own.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;
  // Width of the reset-class field at the bottom of the event vector.
  localparam int RESET_BYTE = 8;

  // Decision strobes from control to datapath, valid in the stepping cycle.
  typedef struct packed {
    logic selReset;
    logic selIrq;
  } gate_strobe_t;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int WIDTH = 8,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any,
  output logic [IDXW-1:0]  idx
);
  // Lowest set index wins.
  always_comb begin
    idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDXW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/evt_gate_datapath.sv
module evt_gate_datapath
  import evt_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int EVW = RESET_BYTE + NUM_IRQ,
  localparam int CW = $clog2(EVW),
  localparam int RIW = $clog2(RESET_BYTE),
  localparam int IIW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EVW-1:0]     eventVec,
  input  logic [NUM_IRQ-1:0] intMask,
  input  gate_strobe_t       strobes,
  output logic               resetAny,
  output logic               irqAny,
  output logic [CW-1:0]      causeIdx
);
  logic [RESET_BYTE-1:0] resetField;
  logic [NUM_IRQ-1:0]    irqLive;
  logic [RIW-1:0]        resetWin;
  logic [IIW-1:0]        irqWin;
  logic [CW-1:0]         causeNext;

  assign resetField = eventVec[RESET_BYTE-1:0];
  assign irqLive    = eventVec[EVW-1:RESET_BYTE] & intMask;

  evt_prio_enc #(.WIDTH(RESET_BYTE)) uResetEnc (
    .vec(resetField),
    .any(resetAny),
    .idx(resetWin)
  );

  evt_prio_enc #(.WIDTH(NUM_IRQ)) uIrqEnc (
    .vec(irqLive),
    .any(irqAny),
    .idx(irqWin)
  );

  always_comb begin
    if (strobes.selReset)    causeNext = CW'(resetWin);
    else if (strobes.selIrq) causeNext = CW'(RESET_BYTE) + CW'(irqWin);
    else                     causeNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) causeIdx <= '0;
    else     causeIdx <= causeNext;
  end
endmodule

// File: rtl/evt_gate_control.sv
module evt_gate_control
  import evt_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         pipeStep,
  input  logic         resetAny,
  input  logic         irqAny,
  input  logic         intEnable,
  input  logic         excLevel,
  input  logic         errLevel,
  output gate_strobe_t strobes,
  output logic         takeReset,
  output logic         takeIrq
);
  logic holdOff;
  logic irqAllowed;
  logic levelSeen;

  assign levelSeen  = excLevel | errLevel;
  assign irqAllowed = intEnable & ~levelSeen & ~holdOff;

  always_comb begin
    strobes.selReset = pipeStep & resetAny & ~takeReset;
    strobes.selIrq   = pipeStep & ~resetAny & irqAny & irqAllowed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      takeReset <= 1'b0;
      takeIrq   <= 1'b0;
      holdOff   <= 1'b0;
    end else begin
      takeReset <= strobes.selReset;
      takeIrq   <= strobes.selIrq;
      if (strobes.selReset || strobes.selIrq) holdOff <= 1'b1;
      else if (levelSeen)                      holdOff <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_gate.sv
module evt_gate
  import evt_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int EVW = RESET_BYTE + NUM_IRQ,
  localparam int CW = $clog2(EVW)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pipeStep,
  input  logic [EVW-1:0]     eventVec,
  input  logic               intEnable,
  input  logic               excLevel,
  input  logic               errLevel,
  input  logic [NUM_IRQ-1:0] intMask,
  output logic               takeReset,
  output logic               takeIrq,
  output logic [CW-1:0]      causeIdx
);
  gate_strobe_t strobes;
  logic resetAny;
  logic irqAny;

  evt_gate_control uCtrl (
    .clk(clk),
    .rst(rst),
    .pipeStep(pipeStep),
    .resetAny(resetAny),
    .irqAny(irqAny),
    .intEnable(intEnable),
    .excLevel(excLevel),
    .errLevel(errLevel),
    .strobes(strobes),
    .takeReset(takeReset),
    .takeIrq(takeIrq)
  );

  evt_gate_datapath #(.NUM_IRQ(NUM_IRQ)) uData (
    .clk(clk),
    .rst(rst),
    .eventVec(eventVec),
    .intMask(intMask),
    .strobes(strobes),
    .resetAny(resetAny),
    .irqAny(irqAny),
    .causeIdx(causeIdx)
  );
endmodule

// File: rtl/evt_gate_checker.sv
module evt_gate_checker #(
  parameter int NUM_IRQ = 8,
  localparam int EVW = 8 + NUM_IRQ,
  localparam int CW = $clog2(EVW)
) (
  input logic               clk,
  input logic               rst,
  input logic               pipeStep,
  input logic [EVW-1:0]     eventVec,
  input logic               intEnable,
  input logic               excLevel,
  input logic               errLevel,
  input logic [NUM_IRQ-1:0] intMask,
  input logic               takeReset,
  input logic               takeIrq,
  input logic [CW-1:0]      causeIdx
);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (eventVec == '0) |=> (!takeReset && !takeIrq));

  p_reset_take_r3: assert property (@(posedge clk) disable iff (rst)
    (pipeStep && (|eventVec[7:0]) && !takeReset) |=> takeReset);

  p_irq_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (!intEnable || excLevel || errLevel) |=> !takeIrq);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (rst)
    ((eventVec[EVW-1:8] & intMask) == '0) |=> !takeIrq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> (causeIdx >= CW'(8)));

  p_reset_override_r8: assert property (@(posedge clk) disable iff (rst)
    (pipeStep && (|eventVec[7:0])) |=> !takeIrq);

  p_step_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !pipeStep |=> (!takeReset && !takeIrq));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    takeReset |=> !takeReset);

  p_idle_cause_r10: assert property (@(posedge clk) disable iff (rst)
    (!takeReset && !takeIrq) |-> (causeIdx == '0));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(takeReset && takeIrq));
endmodule

bind evt_gate evt_gate_checker #(.NUM_IRQ(NUM_IRQ)) uChk (
  .clk(clk),
  .rst(rst),
  .pipeStep(pipeStep),
  .eventVec(eventVec),
  .intEnable(intEnable),
  .excLevel(excLevel),
  .errLevel(errLevel),
  .intMask(intMask),
  .takeReset(takeReset),
  .takeIrq(takeIrq),
  .causeIdx(causeIdx)
);

// File: tb/evt_gate_test.sv
module evt_gate_test;
  logic clk = 1'b0;
  logic rst;
  logic pipeStep;
  logic [15:0] eventVec;
  logic intEnable, excLevel, errLevel;
  logic [7:0] intMask;
  logic takeReset, takeIrq;
  logic [3:0] causeIdx;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  evt_gate #(.NUM_IRQ(8)) uut (
    .clk(clk), .rst(rst), .pipeStep(pipeStep), .eventVec(eventVec),
    .intEnable(intEnable), .excLevel(excLevel), .errLevel(errLevel),
    .intMask(intMask), .takeReset(takeReset), .takeIrq(takeIrq),
    .causeIdx(causeIdx)
  );

  typedef struct packed {
    logic        ps;
    logic [15:0] ev;
    logic        ie;
    logic        exl;
    logic        erl;
    logic [7:0]  msk;
    logic        tr;
    logic        ti;
    logic [3:0]  cause;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd2},  // R2 idle
    '{1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd0,  4'd6},  // R6 masked
    '{1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd5},  // R5 disabled
    '{1'b1, 16'h0100, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd5},  // R5 exception level
    '{1'b1, 16'h0100, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd5},  // R5 error level
    '{1'b1, 16'h0A00, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 4'd9,  4'd7},  // R7 lowest line
    '{1'b1, 16'h0A00, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd11}, // R11 held off
    '{1'b1, 16'h0A00, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd11}, // R11 level seen
    '{1'b1, 16'h0A00, 1'b1, 1'b0, 1'b0, 8'h08, 1'b0, 1'b1, 4'd11, 4'd6},  // R6 mask picks line 3
    '{1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd11}, // R11 clear hold
    '{1'b0, 16'h0100, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd9},  // R9 no step
    '{1'b1, 16'h0006, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 4'd1,  4'd4},  // R4 soft over NMI
    '{1'b1, 16'h0006, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 4'd0,  4'd10}, // R10 pulse gap
    '{1'b1, 16'h0005, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 4'd0,  4'd3},  // R3 cold wins
    '{1'b1, 16'h0080, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd10}, // R10 no back-to-back
    '{1'b1, 16'h0180, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 4'd7,  4'd8},  // R8 reset beats irq
    '{1'b0, 16'h0100, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 4'd0,  4'd9}   // R9 no step
  };

  task automatic check(input logic [3:0] req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input logic [3:0] req, input logic tr,
                           input logic ti, input logic [3:0] cause);
    check(req, "takeReset", {3'b0, takeReset}, {3'b0, tr});
    check(req, "takeIrq", {3'b0, takeIrq}, {3'b0, ti});
    check(req, "causeIdx", causeIdx, cause);
    check(4'd12, "exclusive", {3'b0, takeReset & takeIrq}, 4'd0);  // R12
  endtask

  task automatic drive(input logic ps, input logic [15:0] ev, input logic ie,
                       input logic exl, input logic erl, input logic [7:0] msk);
    pipeStep = ps; eventVec = ev; intEnable = ie;
    excLevel = exl; errLevel = erl; intMask = msk;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b1, 16'h0107, 1'b1, 1'b0, 1'b0, 8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOuts(4'd1, 1'b0, 1'b0, 4'd0);  // R1 held in reset with events pending
    drive(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 8'hFF);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    checkOuts(4'd1, 1'b0, 1'b0, 4'd0);  // R1 first cycle after reset

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ps, VECS[i].ev, VECS[i].ie, VECS[i].exl, VECS[i].erl, VECS[i].msk);
      @(posedge clk); @(negedge clk);
      checkOuts(VECS[i].req, VECS[i].tr, VECS[i].ti, VECS[i].cause);
    end

    // R1: reset clears the hold-off left by the last take.
    rst = 1'b1;
    drive(1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 8'hFF);
    @(posedge clk); @(negedge clk);
    checkOuts(4'd1, 1'b0, 1'b0, 4'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    checkOuts(4'd1, 1'b0, 1'b1, 4'd15);  // R7 highest line alone

    // R11: a held line stays refused over several steps without the level.
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      checkOuts(4'd11, 1'b0, 1'b0, 4'd0);
    end

    // R3: reset class taken with every status input hostile.
    drive(1'b1, 16'h0004, 1'b0, 1'b1, 1'b1, 8'h00);
    @(posedge clk); @(negedge clk);
    checkOuts(4'd3, 1'b1, 1'b0, 4'd2);  // NMI alone
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00);
    @(posedge clk); @(negedge clk);
    checkOuts(4'd2, 1'b0, 1'b0, 4'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule